// File: doc/BRIEF.md
# Phased Stride Value Predictor Table

This block is a direct-mapped table that guesses the result of a decoded micro-operation before the operation executes. Each entry is named by a location in the micro-operation cache, not by an instruction address. The reason is that one address can expand into several micro-operations, so an address cannot tell them apart. Each entry learns a last value and a stride. The guess for the next result is the last value plus the stride.

Every entry is in one of two phases. In the training phase the entry follows committed results and counts how many guesses in a row would have been right. When that count saturates, the entry moves to the deployment phase. From then on it ignores training traffic and serves predictions on the lookup port. The validation port compares each served prediction with the real result. A correct result advances the entry by one stride. A wrong result raises a one-cycle mispredict flag and sends the entry back to training.

The table has three request ports that can all be active in the same cycle: one for lookup, one for training with committed results, and one for validation. Every read sees the contents the table held before that cycle's writes.

Top module: `vp_phase_table`

## Requirements
- R1: After reset, every entry is invalid, `lk_valid` and `mispredict` are 0, and a lookup of any slot returns no prediction.
- R2: A lookup returns its result one cycle after `lk_req`. The entry is picked by slot bits [5:0], and slot bits [9:6] must match the stored tag. `lk_valid` is 1 only when the entry is valid, the tag matches and the entry is deployed; `lk_value` is then last value plus stride. In every other case both outputs are 0.
- R3: A training update whose tag misses, or that lands on an invalid entry, writes a new entry: valid, the new tag, last value set to the result, stride 0, confidence 0, training phase.
- R4: A training update that hits an entry in training, with a result equal to last value plus stride, increments the 3-bit confidence and sets last value to the result.
- R5: A training update that hits an entry in training, with any other result, clears confidence, sets the stride to result minus last value, and sets last value to the result.
- R6: An entry enters the deployment phase in the same update that brings its confidence to 7. Before that, a lookup gives no prediction for it.
- R7: A training update that hits a deployed entry is ignored; later lookups return the same prediction as before.
- R8: A validation that hits a deployed entry, with an actual value equal to last value plus stride, sets last value to that sum. The entry stays deployed and no mispredict is raised.
- R9: A validation that hits a deployed entry with any other actual value raises `mispredict` for exactly the next cycle. It clears confidence, returns the entry to training, sets last value to the actual value and keeps the stride.
- R10: A validation that misses the tag, or that hits an entry in training, has no effect on the entry and raises no mispredict.
- R11: A lookup issued in the same cycle as a training or validation write to the same entry returns the contents held before that write.
- R12: If a training replacement and a validation target the same index in one cycle, the replacement is what gets stored. The mispredict decision is still made against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_slot | input | 10 | Micro-operation cache slot to look up |
| lk_valid | output | 1 | Registered: a prediction is available |
| lk_value | output | 64 | Registered predicted value, 0 when not valid |
| tr_req | input | 1 | Training update with a committed result |
| tr_slot | input | 10 | Slot of the committed micro-operation |
| tr_result | input | 64 | Committed result value |
| va_req | input | 1 | Validation of a served prediction |
| va_slot | input | 10 | Slot being validated |
| va_actual | input | 64 | Actual result of the predicted micro-operation |
| mispredict | output | 1 | One-cycle pulse after a wrong deployed prediction |

## Verification
Lookups and writes often meet on the same entry in the same cycle, so the bench does this on purpose. It issues a lookup together with the training update that deploys an entry, and again together with a validation that advances one. In both cases the returned value must match the entry as it was before the write. A second collision is a training replacement and a validation on the same index. Here the bench expects the mispredict decision to come from the old deployed entry, while later lookups show only the newly installed one. The constrained random phase mixes all three ports over a few indexes and two tags, so these overlaps also occur without being planned.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam int unsigned VP_SLOT_W = 10;
  localparam int unsigned VP_IDX_W  = 6;
  localparam int unsigned VP_VAL_W  = 64;
  localparam int unsigned VP_CONF_W = 3;

  typedef enum logic {
    PH_TRAIN  = 1'b0,
    PH_DEPLOY = 1'b1
  } phase_e;
endpackage

// File: rtl/vp_entry_store.sv
// Register array of table entries: two write ports (A wins on a shared index),
// three combinational read ports that return pre-write contents.
module vp_entry_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned ENT_W = 137
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [ENT_W-1:0] a_wdata,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [ENT_W-1:0] b_wdata,
  input  logic [IDX_W-1:0] r0_idx,
  output logic [ENT_W-1:0] r0_data,
  input  logic [IDX_W-1:0] r1_idx,
  output logic [ENT_W-1:0] r1_data,
  input  logic [IDX_W-1:0] r2_idx,
  output logic [ENT_W-1:0] r2_data
);
  logic [DEPTH-1:0][ENT_W-1:0] ent_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic             sel_a;
    logic             sel_b;
    logic             ent_en;
    logic [ENT_W-1:0] ent_d;
    logic [ENT_W-1:0] ent_q;

    always_comb begin
      sel_a  = a_we && (a_idx == IDX_W'(g));
      sel_b  = b_we && (b_idx == IDX_W'(g));
      ent_en = sel_a || sel_b;
      ent_d  = sel_a ? a_wdata : b_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign ent_flat[g] = ent_q;
  end

  assign r0_data = ent_flat[r0_idx];
  assign r1_data = ent_flat[r1_idx];
  assign r2_data = ent_flat[r2_idx];
endmodule

// File: rtl/vp_train_upd.sv
// Next-entry computation for the training/commit port.
module vp_train_upd
  import vp_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned VAL_W  = 64,
  parameter int unsigned CONF_W = 3
) (
  input  logic              req,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [VAL_W-1:0]  result,
  input  logic              ent_vld,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [VAL_W-1:0]  ent_last,
  input  logic [VAL_W-1:0]  ent_stride,
  input  logic [CONF_W-1:0] ent_conf,
  input  phase_e            ent_phase,
  output logic              we,
  output logic [TAG_W-1:0]  nw_tag,
  output logic [VAL_W-1:0]  nw_last,
  output logic [VAL_W-1:0]  nw_stride,
  output logic [CONF_W-1:0] nw_conf,
  output phase_e            nw_phase
);
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic             tag_hit;
  logic [VAL_W-1:0] guess;
  logic [CONF_W-1:0] conf_inc;

  always_comb begin
    tag_hit   = ent_vld && (ent_tag == req_tag);
    guess     = ent_last + ent_stride;
    conf_inc  = (ent_conf == CONF_MAX) ? CONF_MAX : ent_conf + 1'b1;
    we        = 1'b0;
    nw_tag    = ent_tag;
    nw_last   = ent_last;
    nw_stride = ent_stride;
    nw_conf   = ent_conf;
    nw_phase  = ent_phase;
    if (req) begin
      if (!tag_hit) begin
        we        = 1'b1;
        nw_tag    = req_tag;
        nw_last   = result;
        nw_stride = '0;
        nw_conf   = '0;
        nw_phase  = PH_TRAIN;
      end else if (ent_phase == PH_TRAIN) begin
        we      = 1'b1;
        nw_last = result;
        if (result == guess) begin
          nw_conf  = conf_inc;
          nw_phase = (conf_inc == CONF_MAX) ? PH_DEPLOY : PH_TRAIN;
        end else begin
          nw_conf   = '0;
          nw_stride = result - ent_last;
          nw_phase  = PH_TRAIN;
        end
      end
    end
  end
endmodule

// File: rtl/vp_valid_upd.sv
// Next-entry computation for the validation port.
module vp_valid_upd
  import vp_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned VAL_W  = 64,
  parameter int unsigned CONF_W = 3
) (
  input  logic              req,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [VAL_W-1:0]  actual,
  input  logic              ent_vld,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [VAL_W-1:0]  ent_last,
  input  logic [VAL_W-1:0]  ent_stride,
  input  logic [CONF_W-1:0] ent_conf,
  input  phase_e            ent_phase,
  output logic              we,
  output logic              wrong,
  output logic [VAL_W-1:0]  nw_last,
  output logic [CONF_W-1:0] nw_conf,
  output phase_e            nw_phase
);
  logic             live;
  logic [VAL_W-1:0] guess;

  always_comb begin
    live     = req && ent_vld && (ent_tag == req_tag) && (ent_phase == PH_DEPLOY);
    guess    = ent_last + ent_stride;
    we       = live;
    wrong    = live && (actual != guess);
    nw_last  = ent_last;
    nw_conf  = ent_conf;
    nw_phase = ent_phase;
    if (live) begin
      if (wrong) begin
        nw_last  = actual;
        nw_conf  = '0;
        nw_phase = PH_TRAIN;
      end else begin
        nw_last  = guess;
      end
    end
  end
endmodule

// File: rtl/vp_lookup.sv
// Registered lookup result stage.
module vp_lookup
  import vp_pkg::*;
#(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned VAL_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [VAL_W-1:0] ent_last,
  input  logic [VAL_W-1:0] ent_stride,
  input  phase_e           ent_phase,
  output logic             valid_q,
  output logic [VAL_W-1:0] value_q
);
  logic             valid_d;
  logic [VAL_W-1:0] value_d;
  logic             out_en;

  always_comb begin
    out_en  = 1'b1;
    valid_d = req && ent_vld && (ent_tag == req_tag) && (ent_phase == PH_DEPLOY);
    value_d = valid_d ? (ent_last + ent_stride) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      value_q <= '0;
    end else if (out_en) begin
      valid_q <= valid_d;
      value_q <= value_d;
    end
  end
endmodule

// File: rtl/vp_phase_table.sv
module vp_phase_table
  import vp_pkg::*;
#(
  parameter int unsigned SLOT_W = VP_SLOT_W,
  parameter int unsigned IDX_W  = VP_IDX_W,
  parameter int unsigned VAL_W  = VP_VAL_W,
  parameter int unsigned CONF_W = VP_CONF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [SLOT_W-1:0] lk_slot,
  output logic              lk_valid,
  output logic [VAL_W-1:0]  lk_value,
  input  logic              tr_req,
  input  logic [SLOT_W-1:0] tr_slot,
  input  logic [VAL_W-1:0]  tr_result,
  input  logic              va_req,
  input  logic [SLOT_W-1:0] va_slot,
  input  logic [VAL_W-1:0]  va_actual,
  output logic              mispredict
);
  localparam int unsigned TAG_W = SLOT_W - IDX_W;
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned ENT_W = 1 + TAG_W + 2 * VAL_W + CONF_W + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       sys_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign sys_rst_n = rst_pipe[1];

  // entry read data, packed as {vld, tag, last, stride, conf, phase}
  logic [ENT_W-1:0] lk_ent, tr_ent, va_ent;
  logic [ENT_W-1:0] tr_wdata, va_wdata;

  logic              lk_rd_vld, tr_rd_vld, va_rd_vld;
  logic [TAG_W-1:0]  lk_rd_tag, tr_rd_tag, va_rd_tag;
  logic [VAL_W-1:0]  lk_rd_last, tr_rd_last, va_rd_last;
  logic [VAL_W-1:0]  lk_rd_stride, tr_rd_stride, va_rd_stride;
  logic [CONF_W-1:0] lk_rd_conf, tr_rd_conf, va_rd_conf;
  phase_e            lk_rd_phase, tr_rd_phase, va_rd_phase;

  assign {lk_rd_vld, lk_rd_tag, lk_rd_last, lk_rd_stride, lk_rd_conf} = lk_ent[ENT_W-1:1];
  assign lk_rd_phase = phase_e'(lk_ent[0]);
  assign {tr_rd_vld, tr_rd_tag, tr_rd_last, tr_rd_stride, tr_rd_conf} = tr_ent[ENT_W-1:1];
  assign tr_rd_phase = phase_e'(tr_ent[0]);
  assign {va_rd_vld, va_rd_tag, va_rd_last, va_rd_stride, va_rd_conf} = va_ent[ENT_W-1:1];
  assign va_rd_phase = phase_e'(va_ent[0]);

  // training port
  logic              tr_we;
  logic [TAG_W-1:0]  tr_nw_tag;
  logic [VAL_W-1:0]  tr_nw_last, tr_nw_stride;
  logic [CONF_W-1:0] tr_nw_conf;
  phase_e            tr_nw_phase;

  vp_train_upd #(.TAG_W(TAG_W), .VAL_W(VAL_W), .CONF_W(CONF_W)) u_train (
    .req        (tr_req),
    .req_tag    (tr_slot[SLOT_W-1:IDX_W]),
    .result     (tr_result),
    .ent_vld    (tr_rd_vld),
    .ent_tag    (tr_rd_tag),
    .ent_last   (tr_rd_last),
    .ent_stride (tr_rd_stride),
    .ent_conf   (tr_rd_conf),
    .ent_phase  (tr_rd_phase),
    .we         (tr_we),
    .nw_tag     (tr_nw_tag),
    .nw_last    (tr_nw_last),
    .nw_stride  (tr_nw_stride),
    .nw_conf    (tr_nw_conf),
    .nw_phase   (tr_nw_phase)
  );
  assign tr_wdata = {1'b1, tr_nw_tag, tr_nw_last, tr_nw_stride, tr_nw_conf, tr_nw_phase};

  // validation port
  logic              va_we, va_wrong;
  logic [VAL_W-1:0]  va_nw_last;
  logic [CONF_W-1:0] va_nw_conf;
  phase_e            va_nw_phase;

  vp_valid_upd #(.TAG_W(TAG_W), .VAL_W(VAL_W), .CONF_W(CONF_W)) u_valid (
    .req        (va_req),
    .req_tag    (va_slot[SLOT_W-1:IDX_W]),
    .actual     (va_actual),
    .ent_vld    (va_rd_vld),
    .ent_tag    (va_rd_tag),
    .ent_last   (va_rd_last),
    .ent_stride (va_rd_stride),
    .ent_conf   (va_rd_conf),
    .ent_phase  (va_rd_phase),
    .we         (va_we),
    .wrong      (va_wrong),
    .nw_last    (va_nw_last),
    .nw_conf    (va_nw_conf),
    .nw_phase   (va_nw_phase)
  );
  assign va_wdata = {va_rd_vld, va_rd_tag, va_nw_last, va_rd_stride, va_nw_conf, va_nw_phase};

  // storage: training replacement wins over validation on a shared index
  vp_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .a_we    (tr_we),
    .a_idx   (tr_slot[IDX_W-1:0]),
    .a_wdata (tr_wdata),
    .b_we    (va_we),
    .b_idx   (va_slot[IDX_W-1:0]),
    .b_wdata (va_wdata),
    .r0_idx  (lk_slot[IDX_W-1:0]),
    .r0_data (lk_ent),
    .r1_idx  (tr_slot[IDX_W-1:0]),
    .r1_data (tr_ent),
    .r2_idx  (va_slot[IDX_W-1:0]),
    .r2_data (va_ent)
  );

  // lookup result
  vp_lookup #(.TAG_W(TAG_W), .VAL_W(VAL_W)) u_lookup (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .req        (lk_req),
    .req_tag    (lk_slot[SLOT_W-1:IDX_W]),
    .ent_vld    (lk_rd_vld),
    .ent_tag    (lk_rd_tag),
    .ent_last   (lk_rd_last),
    .ent_stride (lk_rd_stride),
    .ent_phase  (lk_rd_phase),
    .valid_q    (lk_valid),
    .value_q    (lk_value)
  );

  // mispredict pulse
  logic mp_d, mp_q, mp_en;

  always_comb begin
    mp_en = 1'b1;
    mp_d  = va_we && va_wrong;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      mp_q <= 1'b0;
    end else if (mp_en) begin
      mp_q <= mp_d;
    end
  end
  assign mispredict = mp_q;
endmodule

// File: rtl/vp_phase_table_chk.sv
module vp_phase_table_chk
  import vp_pkg::*;
#(
  parameter int unsigned VAL_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_valid,
  input logic [VAL_W-1:0] lk_value,
  input logic             va_req,
  input logic             mispredict,
  input phase_e           lk_rd_phase,
  input phase_e           va_rd_phase
);
  p_no_req_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_valid);

  p_idle_value_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (lk_value == '0));

  p_valid_from_deployed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && (lk_rd_phase == PH_TRAIN) |=> !lk_valid);

  p_no_val_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !va_req |=> !mispredict);

  p_flag_needs_deployed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    va_req && (va_rd_phase == PH_TRAIN) |=> !mispredict);
endmodule

bind vp_phase_table vp_phase_table_chk #(.VAL_W(VAL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_req      (lk_req),
  .lk_valid    (lk_valid),
  .lk_value    (lk_value),
  .va_req      (va_req),
  .mispredict  (mispredict),
  .lk_rd_phase (lk_rd_phase),
  .va_rd_phase (va_rd_phase)
);

// File: tb/vp_phase_table_test.sv
`timescale 1ns/1ps
module vp_phase_table_test;
  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [9:0]  lk_slot;
  logic        lk_valid;
  logic [63:0] lk_value;
  logic        tr_req;
  logic [9:0]  tr_slot;
  logic [63:0] tr_result;
  logic        va_req;
  logic [9:0]  va_slot;
  logic [63:0] va_actual;
  logic        mispredict;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // bench model of the table
  bit          m_vld [64];
  logic [3:0]  m_tag [64];
  logic [63:0] m_last [64];
  logic [63:0] m_str [64];
  int          m_conf [64];
  bit          m_dep [64];

  vp_phase_table uut (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_slot(lk_slot), .lk_valid(lk_valid), .lk_value(lk_value),
    .tr_req(tr_req), .tr_slot(tr_slot), .tr_result(tr_result),
    .va_req(va_req), .va_slot(va_slot), .va_actual(va_actual),
    .mispredict(mispredict)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit m_hit(input logic [9:0] s);
    return m_vld[s[5:0]] && (m_tag[s[5:0]] == s[9:6]);
  endfunction

  function automatic logic [63:0] m_guess(input logic [9:0] s);
    return m_last[s[5:0]] + m_str[s[5:0]];
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; expectations from the model before its update
  task automatic step(input bit lr, input logic [9:0] ls,
                      input bit tr, input logic [9:0] ts, input logic [63:0] tv,
                      input bit vr, input logic [9:0] vs, input logic [63:0] vv,
                      input string req);
    bit          e_lv, e_mp, t_we, v_we;
    logic [63:0] e_lval;
    int          ti, vi, li;
    logic [3:0]  n_tag;
    logic [63:0] n_last, n_str;
    int          n_conf;
    bit          n_dep;
    lk_req = lr; lk_slot = ls;
    tr_req = tr; tr_slot = ts; tr_result = tv;
    va_req = vr; va_slot = vs; va_actual = vv;
    li = int'(ls[5:0]); ti = int'(ts[5:0]); vi = int'(vs[5:0]);
    e_lv   = lr && m_hit(ls) && m_dep[li];
    e_lval = e_lv ? m_guess(ls) : 64'd0;
    v_we   = vr && m_hit(vs) && m_dep[vi];
    e_mp   = v_we && (vv != m_guess(vs));
    // training decision from old contents
    t_we = 1'b0; n_tag = m_tag[ti]; n_last = m_last[ti]; n_str = m_str[ti];
    n_conf = m_conf[ti]; n_dep = m_dep[ti];
    if (tr) begin
      if (!m_hit(ts)) begin
        t_we = 1'b1; n_tag = ts[9:6]; n_last = tv; n_str = 64'd0; n_conf = 0; n_dep = 1'b0;
      end else if (!m_dep[ti]) begin
        t_we = 1'b1;
        if (tv == m_guess(ts)) begin
          n_conf = (m_conf[ti] == 7) ? 7 : m_conf[ti] + 1;
          n_dep  = (n_conf == 7);
        end else begin
          n_conf = 0; n_str = tv - m_last[ti]; n_dep = 1'b0;
        end
        n_last = tv;
      end
    end
    if (v_we) begin
      if (e_mp) begin
        m_last[vi] = vv; m_conf[vi] = 0; m_dep[vi] = 1'b0;
      end else begin
        m_last[vi] = m_guess(vs);
      end
    end
    if (t_we) begin
      m_vld[ti] = 1'b1; m_tag[ti] = n_tag; m_last[ti] = n_last;
      m_str[ti] = n_str; m_conf[ti] = n_conf; m_dep[ti] = n_dep;
    end
    @(negedge clk);
    check(req, "lk_valid", {63'd0, lk_valid}, {63'd0, e_lv});
    check(req, "lk_value", lk_value, e_lval);
    check(req, "mispredict", {63'd0, mispredict}, {63'd0, e_mp});
  endtask

  task automatic look(input logic [9:0] s, input string req);
    step(1, s, 0, 10'd0, 64'd0, 0, 10'd0, 64'd0, req);
  endtask

  task automatic train(input logic [9:0] s, input logic [63:0] v, input string req);
    step(0, 10'd0, 1, s, v, 0, 10'd0, 64'd0, req);
  endtask

  task automatic valid8(input logic [9:0] s, input logic [63:0] v, input string req);
    step(0, 10'd0, 0, 10'd0, 64'd0, 1, s, v, req);
  endtask

  initial begin
    localparam logic [9:0] SA = {4'd3, 6'd10};
    localparam logic [9:0] SB = {4'd0, 6'd20};
    localparam logic [9:0] SB_OTHER = {4'd1, 6'd20};
    localparam logic [9:0] SC = {4'd2, 6'd20};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_last[i] = '0; m_str[i] = '0; m_conf[i] = 0; m_dep[i] = 0;
    end
    rst_n = 1'b0;
    lk_req = 0; lk_slot = '0; tr_req = 0; tr_slot = '0; tr_result = '0;
    va_req = 0; va_slot = '0; va_actual = '0;
    repeat (3) @(negedge clk);
    check("R1", "lk_valid in reset", {63'd0, lk_valid}, 64'd0);
    check("R1", "mispredict in reset", {63'd0, mispredict}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: nothing predicted after reset
    look(SA, "R1"); look(SB, "R1"); look(10'd0, "R1");
    // R3: replacement starts in training
    train(SA, 64'd100, "R3");
    look(SA, "R3");
    // R5: wrong result learns stride 10
    train(SA, 64'd110, "R5");
    // R4: six correct results build confidence, still no prediction
    for (int k = 0; k < 6; k++) train(SA, 64'd120 + 64'(k) * 10, "R4");
    look(SA, "R6");
    // R6 with R11: seventh correct result deploys; same-cycle lookup sees old
    step(1, SA, 1, SA, 64'd180, 0, 10'd0, 64'd0, "R11");
    look(SA, "R6");
    // R7: training on deployed entry ignored
    train(SA, 64'd999, "R7");
    look(SA, "R7");
    // R8: correct validation advances
    valid8(SA, 64'd190, "R8");
    look(SA, "R8");
    // R11: lookup with validation of same entry sees old contents
    step(1, SA, 0, 10'd0, 64'd0, 1, SA, 64'd200, "R11");
    look(SA, "R11");
    // R9: wrong validation, one-cycle flag, back to training
    valid8(SA, 64'd5, "R9");
    look(SA, "R9");
    // R10: validation on training entry ignored
    valid8(SA, 64'd15, "R10");
    look(SA, "R10");
    // second entry deployed on constant value
    for (int k = 0; k < 8; k++) train(SB, 64'd7, "R4");
    look(SB, "R6");
    // R10: tag miss on validation
    valid8(SB_OTHER, 64'd1234, "R10");
    look(SB, "R10");
    // R12: replacement and wrong validation on same index in one cycle
    step(0, 10'd0, 1, SC, 64'd50, 1, SB, 64'd99, "R12");
    look(SB, "R12");
    look(SC, "R12");
    for (int k = 0; k < 7; k++) train(SC, 64'd50, "R12");
    look(SC, "R12");
    // constrained random traffic over few indexes and two tags
    for (int n = 0; n < 4000; n++) begin
      logic [9:0]  ls, ts, vs;
      logic [63:0] tv, vv;
      bit lr, tr, vr;
      ls = {($urandom_range(0, 9) < 8) ? 4'd0 : 4'd1, 6'($urandom_range(0, 3))};
      ts = {($urandom_range(0, 9) < 8) ? 4'd0 : 4'd1, 6'($urandom_range(0, 3))};
      vs = {($urandom_range(0, 9) < 8) ? 4'd0 : 4'd1, 6'($urandom_range(0, 3))};
      lr = ($urandom_range(0, 1) == 1);
      tr = ($urandom_range(0, 9) < 6);
      vr = ($urandom_range(0, 9) < 4);
      tv = ($urandom_range(0, 19) < 18) ? m_guess(ts) : {32'd0, $urandom};
      vv = ($urandom_range(0, 9) < 8) ? m_guess(vs) : m_guess(vs) + 64'd1;
      step(lr, ls, tr, ts, tv, vr, vs, vv, "R2");
    end
    step(0, 10'd0, 0, 10'd0, 64'd0, 0, 10'd0, 64'd0, "R9");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule